// File: doc/BRIEF.md
# Missing Clock Failover Controller

This block supervises a primary oscillator clock from a free-running internal reference clock of about 10 MHz. The primary clock drives a toggle flop. The toggle is brought into the reference domain through a synchronizer, and the block counts reference cycles that pass without a toggle edge. When that quiet count reaches a programmable window, the primary clock is declared missing. A sticky failure flag then goes high. The same flag goes to the PWM trip output and to the system clock selector. The selector moves the system clock onto the reference clock without glitches.

The failure also raises a non-maskable interrupt request for each of the two processors and starts a watchdog counter for each one. Recovery software can freeze a processor's counter with a stop pulse, or clear that processor's request. Clearing the request also zeroes its counter. If any counter reaches the programmed limit, the block emits a device reset pulse of fixed width. The reset pulse is timed entirely from the reference clock, so it works with the primary clock dead. A software clear of the failure flag takes effect only after the primary clock has been seen toggling again for one full window.

Top module: `mcf_failover`

## Requirements
- R1: While `arst_n` is low, `clk_fail`, `pwm_trip`, `nmi_req`, `dev_rst`, `pri_active` and `ref_active` are all 0. Some reference cycles after release, the primary source is selected: `pri_active`=1 and `ref_active`=0.
- R2: If the primary clock stops toggling, `clk_fail` rises between `win_cfg`-1 and `win_cfg`+10 reference cycles later. While the primary clock toggles faster than the window, `clk_fail` stays 0.
- R3: `clk_fail` is sticky. A one-cycle `sw_clr_fail` pulse clears it on the next reference edge only if primary edges have been seen for `win_cfg` consecutive reference cycles. Otherwise the pulse is ignored and `clk_fail` stays 1.
- R4: `pri_active` and `ref_active` are never both 1. After a failure, `ref_active`=1, `pri_active`=0 and `sys_clk` follows `ref_clk`. After an accepted clear, the selection returns to the primary clock.
- R5: `pwm_trip` equals `clk_fail`. Both bits of `nmi_req` (bit 0 for processor 0, bit 1 for processor 1) rise on the same reference edge as `clk_fail`.
- R6: If no stop arrives, `dev_rst` rises exactly `wd_limit` reference cycles after the edge on which `clk_fail` rose. It is 0 one cycle earlier.
- R7: A `sw_wd_stop[i]` pulse while `nmi_req[i]` is set freezes that processor's counter. A reset is avoided only when every running counter is stopped.
- R8: A `sw_nmi_clr[i]` pulse clears `nmi_req[i]` on the next edge and zeroes that counter. A later failure restarts the count from zero.
- R9: Each `dev_rst` pulse is exactly 8 reference cycles wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running internal reference clock |
| pri_clk | input | 1 | Primary oscillator clock being supervised |
| arst_n | input | 1 | Asynchronous active-low reset |
| win_cfg | input | 8 | Detection window in reference cycles |
| wd_limit | input | 16 | Watchdog period in reference cycles |
| sw_clr_fail | input | 1 | Clear request for the failure flag (reference domain pulse) |
| sw_wd_stop | input | 2 | Per-processor watchdog stop pulse |
| sw_nmi_clr | input | 2 | Per-processor interrupt clear pulse |
| sys_clk | output | 1 | Glitch-free selected system clock |
| pri_active | output | 1 | Primary source gated onto `sys_clk` |
| ref_active | output | 1 | Reference source gated onto `sys_clk` |
| clk_fail | output | 1 | Sticky missing-clock flag |
| pwm_trip | output | 1 | Failure copy for PWM trip inputs |
| nmi_req | output | 2 | Per-processor non-maskable interrupt request |
| dev_rst | output | 1 | Device reset pulse |

## Verification
All stimulus is driven on reference falling edges and sampled on reference falling edges. A result due on edge N is therefore read in the half-cycle after it. The point where `clk_fail` rises depends on the synchronizer and on the phase of the last primary edge. For that reason the detection time is bracketed: one sample shortly before the window, then a bounded search, with every later count referenced to the first sample that shows the flag. The interrupt requests are checked in that same sample. `dev_rst` is checked at exactly `wd_limit`-1 and `wd_limit` samples after it, and its width is counted sample by sample. Clear pulses are judged on the following sample, and the clock selection is read tens of cycles after a change, because each side waits two of its own falling edges.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int unsigned MCF_NCPU    = 2;
  localparam int unsigned MCF_WIN_W   = 8;
  localparam int unsigned MCF_WD_W    = 16;
  localparam int unsigned MCF_RST_LEN = 8;
  localparam int unsigned MCF_SYNC_N  = 3;
endpackage

// File: rtl/mcf_rst_sync.sv
module mcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/mcf_detect.sv
module mcf_detect #(
  parameter int unsigned WIN_W  = mcf_pkg::MCF_WIN_W,
  parameter int unsigned SYNC_N = mcf_pkg::MCF_SYNC_N
) (
  input  logic             pri_clk,
  input  logic             pri_rst_n,
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic [WIN_W-1:0] win_cfg,
  output logic             miss_o,
  output logic             alive_o
);
  logic              tgl_q;
  logic [SYNC_N-1:0] sync_q;
  logic              seen_edge;
  logic [WIN_W-1:0]  quiet_q, quiet_d;
  logic [WIN_W-1:0]  alive_q, alive_d;

  // primary-domain divide-by-two
  always_ff @(posedge pri_clk or negedge pri_rst_n) begin
    if (!pri_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= ~tgl_q;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_N-2:0], tgl_q};
  end

  assign seen_edge = sync_q[SYNC_N-1] ^ sync_q[SYNC_N-2];
  assign miss_o    = (quiet_q == win_cfg);
  assign alive_o   = (alive_q == win_cfg);

  always_comb begin
    quiet_d = quiet_q;
    alive_d = alive_q;
    if (seen_edge)           quiet_d = '0;
    else if (!miss_o)        quiet_d = quiet_q + 1'b1;
    if (miss_o)              alive_d = '0;
    else if (!alive_o)       alive_d = alive_q + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      quiet_q <= '0;
      alive_q <= '0;
    end else begin
      quiet_q <= quiet_d;
      alive_q <= alive_d;
    end
  end
endmodule

// File: rtl/mcf_clk_mux.sv
module mcf_clk_mux (
  input  logic pri_clk,
  input  logic pri_rst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic use_ref,
  output logic sys_clk,
  output logic pri_act,
  output logic ref_act
);
  logic [1:0] pri_q;
  logic [1:0] ref_q;
  logic       pri_clr_n;

  // a dead primary never falls, so its enable is dropped asynchronously
  assign pri_clr_n = pri_rst_n & ~use_ref;

  always_ff @(negedge pri_clk or negedge pri_clr_n) begin
    if (!pri_clr_n) pri_q <= 2'b00;
    else            pri_q <= {pri_q[0], ~ref_q[1]};
  end

  always_ff @(negedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) ref_q <= 2'b00;
    else            ref_q <= {ref_q[0], use_ref & ~pri_q[1]};
  end

  assign pri_act = pri_q[1];
  assign ref_act = ref_q[1];
  assign sys_clk = (pri_clk & pri_q[1]) | (ref_clk & ref_q[1]);

  AST_MUX_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(pri_act && ref_act)); // R4
endmodule

// File: rtl/mcf_nmi_wd.sv
module mcf_nmi_wd #(
  parameter int unsigned WD_W = mcf_pkg::MCF_WD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fail_rise,
  input  logic            nmi_clr,
  input  logic            wd_stop,
  input  logic [WD_W-1:0] wd_limit,
  output logic            nmi_o,
  output logic            expire_o
);
  logic            flag_q, flag_d;
  logic            stop_q, stop_d;
  logic [WD_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic            run;

  assign cnt_inc  = cnt_q + 1'b1;
  assign run      = flag_q & ~stop_q & (cnt_q != wd_limit);
  assign expire_o = run & ~nmi_clr & ~fail_rise & (cnt_inc == wd_limit);
  assign nmi_o    = flag_q;

  always_comb begin
    flag_d = flag_q;
    stop_d = stop_q;
    cnt_d  = cnt_q;
    if (fail_rise) begin
      flag_d = 1'b1;
      stop_d = 1'b0;
      cnt_d  = '0;
    end else if (nmi_clr) begin
      flag_d = 1'b0;
      stop_d = 1'b0;
      cnt_d  = '0;
    end else begin
      if (wd_stop && flag_q) stop_d = 1'b1;
      if (run)               cnt_d  = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      stop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      stop_q <= stop_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !nmi_clr && !fail_rise) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/mcf_failover.sv
module mcf_failover #(
  parameter int unsigned NCPU    = mcf_pkg::MCF_NCPU,
  parameter int unsigned WIN_W   = mcf_pkg::MCF_WIN_W,
  parameter int unsigned WD_W    = mcf_pkg::MCF_WD_W,
  parameter int unsigned RST_LEN = mcf_pkg::MCF_RST_LEN
) (
  input  logic             ref_clk,
  input  logic             pri_clk,
  input  logic             arst_n,
  input  logic [WIN_W-1:0] win_cfg,
  input  logic [WD_W-1:0]  wd_limit,
  input  logic             sw_clr_fail,
  input  logic [NCPU-1:0]  sw_wd_stop,
  input  logic [NCPU-1:0]  sw_nmi_clr,
  output logic             sys_clk,
  output logic             pri_active,
  output logic             ref_active,
  output logic             clk_fail,
  output logic             pwm_trip,
  output logic [NCPU-1:0]  nmi_req,
  output logic             dev_rst
);
  localparam int unsigned RST_W = $clog2(RST_LEN + 1);

  logic             ref_rst_n, pri_rst_n;
  logic             miss, alive;
  logic             fail_q, fail_d, fail_rise;
  logic [NCPU-1:0]  expire;
  logic [RST_W-1:0] rcnt_q, rcnt_d;

  mcf_rst_sync u_ref_rst (.clk(ref_clk), .arst_n(arst_n), .rst_n_o(ref_rst_n));
  mcf_rst_sync u_pri_rst (.clk(pri_clk), .arst_n(arst_n), .rst_n_o(pri_rst_n));

  mcf_detect #(.WIN_W(WIN_W)) u_detect (
    .pri_clk(pri_clk), .pri_rst_n(pri_rst_n),
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .win_cfg(win_cfg), .miss_o(miss), .alive_o(alive)
  );

  mcf_clk_mux u_mux (
    .pri_clk(pri_clk), .pri_rst_n(pri_rst_n),
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .use_ref(fail_q), .sys_clk(sys_clk),
    .pri_act(pri_active), .ref_act(ref_active)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    mcf_nmi_wd #(.WD_W(WD_W)) u_wd (
      .clk(ref_clk), .rst_n(ref_rst_n),
      .fail_rise(fail_rise), .nmi_clr(sw_nmi_clr[g]), .wd_stop(sw_wd_stop[g]),
      .wd_limit(wd_limit), .nmi_o(nmi_req[g]), .expire_o(expire[g])
    );
  end

  assign fail_rise = miss & ~fail_q;

  always_comb begin
    fail_d = fail_q;
    if (miss)                      fail_d = 1'b1;
    else if (sw_clr_fail && alive) fail_d = 1'b0;
  end

  always_comb begin
    rcnt_d = rcnt_q;
    if (|expire)            rcnt_d = RST_W'(RST_LEN);
    else if (rcnt_q != '0)  rcnt_d = rcnt_q - 1'b1;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      fail_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      fail_q <= fail_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign clk_fail = fail_q;
  assign pwm_trip = fail_q;
  assign dev_rst  = (rcnt_q != '0);

  AST_MISS_SETS_FAIL: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    miss |=> clk_fail); // R2
  AST_FAIL_STICKY: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (clk_fail && !sw_clr_fail) |=> clk_fail); // R3
  AST_NMI_WITH_FAIL: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(clk_fail) |-> (&nmi_req)); // R5
  AST_RST_NEEDS_NMI: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(dev_rst) |-> (|nmi_req)); // R6
  AST_RST_HOLD: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(dev_rst) |=> dev_rst); // R9
endmodule

// File: tb/mcf_failover_bench.sv
`timescale 1ns/1ps
module mcf_failover_bench;
  typedef struct packed {
    logic [7:0]  win;
    logic [15:0] lim;
    logic [1:0]  stop;
    logic        exp_rst;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VEC [NVEC] = '{
    '{win: 8'd16, lim: 16'd20, stop: 2'b00, exp_rst: 1'b1},
    '{win: 8'd32, lim: 16'd40, stop: 2'b11, exp_rst: 1'b0},
    '{win: 8'd12, lim: 16'd10, stop: 2'b01, exp_rst: 1'b1},
    '{win: 8'd64, lim: 16'd30, stop: 2'b10, exp_rst: 1'b1}
  };

  logic        ref_clk = 1'b0, pri_clk = 1'b0, pri_run = 1'b1;
  logic        arst_n;
  logic [7:0]  win_cfg;
  logic [15:0] wd_limit;
  logic        sw_clr_fail;
  logic [1:0]  sw_wd_stop, sw_nmi_clr;
  logic        sys_clk, pri_active, ref_active, clk_fail, pwm_trip, dev_rst;
  logic [1:0]  nmi_req;
  int          checks = 0, fails = 0, cyc = 0;

  always #2.5 ref_clk = ~ref_clk;
  always begin
    #3.5;
    if (pri_run) pri_clk = ~pri_clk;
  end

  mcf_failover u_mcf_failover (
    .ref_clk(ref_clk), .pri_clk(pri_clk), .arst_n(arst_n),
    .win_cfg(win_cfg), .wd_limit(wd_limit), .sw_clr_fail(sw_clr_fail),
    .sw_wd_stop(sw_wd_stop), .sw_nmi_clr(sw_nmi_clr), .sys_clk(sys_clk),
    .pri_active(pri_active), .ref_active(ref_active), .clk_fail(clk_fail),
    .pwm_trip(pwm_trip), .nmi_req(nmi_req), .dev_rst(dev_rst)
  );

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: R2..run actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    arst_n = 1'b0; pri_run = 1'b1;
    sw_clr_fail = 1'b0; sw_wd_stop = 2'b00; sw_nmi_clr = 2'b00;
    repeat (5) @(negedge ref_clk);
    chk("R1 reset outputs", {clk_fail, pwm_trip, nmi_req, dev_rst, pri_active, ref_active}, 0);
    arst_n = 1'b1;
    repeat (30) @(negedge ref_clk);
  endtask

  task automatic wait_fail(output logic got);
    got = 1'b0;
    for (int k = 0; k < 80 && !got; k++) begin
      @(negedge ref_clk);
      if (clk_fail) got = 1'b1;
    end
  endtask

  task automatic pulse_clr();
    sw_clr_fail = 1'b1;
    @(negedge ref_clk);
    sw_clr_fail = 1'b0;
  endtask

  initial begin
    logic got;
    int   width;
    arst_n = 1'b0; win_cfg = 8'd16; wd_limit = 16'd100;
    sw_clr_fail = 1'b0; sw_wd_stop = 2'b00; sw_nmi_clr = 2'b00;

    for (int i = 0; i < NVEC; i++) begin
      win_cfg = VEC[i].win; wd_limit = VEC[i].lim;
      do_reset();
      repeat (40) @(negedge ref_clk);
      chk("R2 no false fail", clk_fail, 0);
      pri_run = 1'b0;
      repeat (int'(VEC[i].win) - 2) @(negedge ref_clk);
      chk("R2 not before window", clk_fail, 0);
      wait_fail(got);
      chk("R2 fail detected", got, 1);
      chk("R5 nmi with fail", nmi_req, 2'b11);
      chk("R5 pwm trip", pwm_trip, 1);
      sw_wd_stop = VEC[i].stop;
      @(negedge ref_clk);
      sw_wd_stop = 2'b00;
      repeat (int'(VEC[i].lim) - 2) @(negedge ref_clk);
      chk("R6 no reset before limit", dev_rst, 0);
      @(negedge ref_clk);
      chk("R6/R7 reset at limit", dev_rst, VEC[i].exp_rst);
      if (VEC[i].exp_rst) begin
        width = 0;
        while (dev_rst && width < 20) begin
          width++;
          @(negedge ref_clk);
        end
        chk("R9 reset width", width, 8);
      end else begin
        repeat (20) @(negedge ref_clk);
        chk("R7 stopped no reset", dev_rst, 0);
      end
    end

    // directed: switching, clears, restart
    win_cfg = 8'd16; wd_limit = 16'd100;
    do_reset();
    chk("R1 primary selected", {pri_active, ref_active}, 2'b10);
    pri_run = 1'b0;
    wait_fail(got);
    chk("R2 directed fail", got, 1);
    repeat (10) @(negedge ref_clk);
    chk("R4 reference selected", {pri_active, ref_active}, 2'b01);
    @(posedge ref_clk); #1;
    chk("R4 sys_clk high", sys_clk, 1);
    @(negedge ref_clk); #1;
    chk("R4 sys_clk low", sys_clk, 0);
    @(negedge ref_clk);
    pulse_clr();
    chk("R3 clear ignored when dead", clk_fail, 1);
    sw_nmi_clr = 2'b01;
    @(negedge ref_clk);
    sw_nmi_clr = 2'b00;
    chk("R8 clear cpu0 only", nmi_req, 2'b10);
    sw_nmi_clr = 2'b10;
    @(negedge ref_clk);
    sw_nmi_clr = 2'b00;
    chk("R8 clear cpu1", nmi_req, 2'b00);
    repeat (120) @(negedge ref_clk);
    chk("R8 cleared counters no reset", dev_rst, 0);
    pri_run = 1'b1;
    repeat (2) @(negedge ref_clk);
    pulse_clr();
    chk("R3 clear ignored before full window", clk_fail, 1);
    repeat (52) @(negedge ref_clk);
    pulse_clr();
    chk("R3 clear accepted", clk_fail, 0);
    chk("R5 trip follows clear", pwm_trip, 0);
    repeat (30) @(negedge ref_clk);
    chk("R4 back to primary", {pri_active, ref_active}, 2'b10);
    pri_run = 1'b0;
    wait_fail(got);
    chk("R8 second fail", got, 1);
    chk("R8 nmi re-raised", nmi_req, 2'b11);
    repeat (99) @(negedge ref_clk);
    chk("R8 restart count no early reset", dev_rst, 0);
    @(negedge ref_clk);
    chk("R8 restart count reset at limit", dev_rst, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule